// File: doc/BRIEF.md
# Quadrature Bus Mouse Controller

This block turns two quadrature channel pairs and three button lines into signed movement counts and button status. A host reaches its registers through a narrow byte bus with three ports: an index port, a data port and a signature port. The index port picks one of the internal registers, and the data port then reads or writes that register. Writing the index port with its top bit set resets the whole controller.

Motion and button activity build up in live state. When the host sets the hold bit in the mode register, the live counts and flags are copied into readable snapshot registers. The live state then clears, so motion that arrives while the host is reading goes into the next snapshot. An interrupt line rises when there is activity. It can be driven directly by activity, by a timer that limits how often it can rise, or by both. The signature port returns one of two values, and the value alternates on every read.

The quadrature and button inputs are taken to be already synchronised and debounced.

Top module: `qmouse_ctrl`

## Requirements
- R1: The index port (bus address 0) stores bits 2:0 of a write as the register selector, and reading the index port returns that selector in bits 2:0 with zeros above. Data port (address 1) selectors: 0 status, 1 X count, 2 Y count, 7 mode. Selectors 3 to 6 read as 0.
- R2: Each quadrature pair is given as {a,b}. A step through 00, 10, 11, 01, 00 adds +1 to the axis's live count, and the reverse order adds -1. A change of both bits at once is ignored.
- R3: Live counts are 8-bit two's complement values. They stop at +127 (0x7F) and at -128 (0x80) instead of wrapping.
- R4: A button change flag, once set, stays set until the next hold rise. Button vector bit 0 is right, bit 1 is middle and bit 2 is left.
- R5: Status layout: bits 2:0 are the buttons down (right, middle, left), bits 5:3 are the change flags in the same order, bit 6 is moved, and bit 7 is packet complete. Packet complete means the snapshot holds any change or movement. Hold is mode bit 5. One cycle after hold goes from 0 to 1, the live state is copied to the snapshot and the live state is cleared.
- R6: While hold stays set, the snapshot does not change, and motion during that time goes into the live counts for the next snapshot. While hold is clear, selectors 0 to 2 read as 0.
- R7: The mode register (selector 7) reads back what was written to it. Writes to selectors 0 to 2 have no effect.
- R8: When mode bit 3 is set and any live change or movement is pending, the interrupt output rises on the next clock.
- R9: When mode bit 4 is set, mode bits 2:0 select the rate at which pending activity can raise the interrupt: 1 = 30 Hz, 2 = 50 Hz, 3 = 100 Hz, 4 = 200 Hz, 6 = every cycle. The timer restarts on every mode write, so at rate code r the interrupt rises CLK_HZ/rate cycles after the write.
- R10: Rate codes 0, 5 and 7 never raise the interrupt. With both enables clear, the interrupt never rises. A hold rise clears the interrupt.
- R11: The signature port (address 2) reads 0xDE and 0x11 on alternate reads, starting with 0xDE. Reads of the other ports do not advance it.
- R12: Quadrature counting happens only while mode bits 7:6 are 00. With any other value, steps are ignored.
- R13: Writing the index port with bit 7 set clears the selector, the mode register, the live state, the snapshot, the interrupt and the signature phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| qx_a | input | 1 | X axis quadrature channel a |
| qx_b | input | 1 | X axis quadrature channel b |
| qy_a | input | 1 | Y axis quadrature channel a |
| qy_b | input | 1 | Y axis quadrature channel b |
| btn | input | 3 | Buttons down, active high: bit 0 right, bit 1 middle, bit 2 left |
| bus_addr | input | 2 | Port select: 0 index, 1 data, 2 signature |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed port |
| irq | output | 1 | Interrupt request, level |

## Verification
The bench builds the block with CLK_HZ = 60000 and 8-bit counts. With that clock, the four timer periods are 2000, 1200, 600 and 300 cycles. The bench can therefore measure the exact number of cycles from a mode write to the interrupt for the 30 Hz and 200 Hz codes, and for the every-cycle code. With 8-bit counts, both saturation limits are reached in about 130 steps. The rate-zero case is shown to stay silent over a window longer than the slowest period.

// File: rtl/qmouse_pkg.sv
package qmouse_pkg;
  localparam logic [1:0] PORT_INDEX = 2'd0;
  localparam logic [1:0] PORT_DATA  = 2'd1;
  localparam logic [1:0] PORT_SIG   = 2'd2;

  localparam logic [2:0] SEL_STATUS = 3'd0;
  localparam logic [2:0] SEL_XCNT   = 3'd1;
  localparam logic [2:0] SEL_YCNT   = 3'd2;
  localparam logic [2:0] SEL_MODE   = 3'd7;

  localparam logic [7:0] SIG_EVEN = 8'hDE;
  localparam logic [7:0] SIG_ODD  = 8'h11;

  localparam logic [2:0] RATE_30     = 3'd1;
  localparam logic [2:0] RATE_50     = 3'd2;
  localparam logic [2:0] RATE_100    = 3'd3;
  localparam logic [2:0] RATE_200    = 3'd4;
  localparam logic [2:0] RATE_ALWAYS = 3'd6;

  typedef struct packed {
    logic [1:0] kind;
    logic       hold;
    logic       tmr_en;
    logic       dat_en;
    logic [2:0] rate;
  } mode_t;

  typedef struct packed {
    logic       pkt;
    logic       moved;
    logic [2:0] chg;
    logic [2:0] down;
  } status_t;
endpackage

// File: rtl/qmouse_quad_dec.sv
module qmouse_quad_dec (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  input  logic a,
  input  logic b,
  output logic up,
  output logic dn
);
  logic [1:0] prev_q, prev_d;
  logic       primed_q, primed_d;
  logic       fwd, rev;

  always_comb begin
    fwd = 1'b0;
    rev = 1'b0;
    case ({prev_q, a, b})
      4'b0010, 4'b1011, 4'b1101, 4'b0100: fwd = 1'b1;
      4'b1000, 4'b1110, 4'b0111, 4'b0001: rev = 1'b1;
      default: ;
    endcase
    up       = fwd & primed_q & en;
    dn       = rev & primed_q & en;
    prev_d   = {a, b};
    primed_d = ~clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= 2'b00;
      primed_q <= 1'b0;
    end else begin
      prev_q   <= prev_d;
      primed_q <= primed_d;
    end
  end
endmodule

// File: rtl/qmouse_satcnt.sv
module qmouse_satcnt #(
  parameter int W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                take,
  input  logic                up,
  input  logic                dn,
  output logic signed [W-1:0] cnt
);
  localparam logic signed [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
  localparam logic signed [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

  logic signed [W-1:0] cnt_q, cnt_d, base;

  always_comb begin
    base  = take ? '0 : cnt_q;
    cnt_d = base;
    if (up && !dn)
      cnt_d = (base == MAXV) ? MAXV : base + W'(1);
    else if (dn && !up)
      cnt_d = (base == MINV) ? MINV : base - W'(1);
    if (clr)
      cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/qmouse_rate_timer.sv
module qmouse_rate_timer #(
  parameter int CLK_HZ = 100_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart,
  input  logic [2:0] rate,
  output logic       tick
);
  import qmouse_pkg::*;

  localparam int P30  = CLK_HZ / 30;
  localparam int P50  = CLK_HZ / 50;
  localparam int P100 = CLK_HZ / 100;
  localparam int P200 = CLK_HZ / 200;
  localparam int CW   = $clog2(P30 + 1);

  logic [CW-1:0] cnt_q, cnt_d, period;
  logic          has_period, at_end, cnt_en;

  always_comb begin
    case (rate)
      RATE_30:  period = CW'(P30);
      RATE_50:  period = CW'(P50);
      RATE_100: period = CW'(P100);
      RATE_200: period = CW'(P200);
      default:  period = '0;
    endcase
    has_period = (period != '0);
    at_end     = has_period && (cnt_q == period - CW'(1));
    tick       = (rate == RATE_ALWAYS) | at_end;
    cnt_en     = restart | has_period;
    if (restart || !has_period || at_end) cnt_d = '0;
    else                                  cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/qmouse_ctrl.sv
module qmouse_ctrl #(
  parameter int CLK_HZ = 100_000_000,
  parameter int CNT_W  = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       qx_a,
  input  logic       qx_b,
  input  logic       qy_a,
  input  logic       qy_b,
  input  logic [2:0] btn,
  input  logic [1:0] bus_addr,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       irq
);
  import qmouse_pkg::*;

  localparam int DATA_W = 8;
  localparam int AXES   = 2;

  logic [AXES-1:0] qa, qb, step_up, step_dn;
  logic signed [CNT_W-1:0] live_cnt [AXES];

  logic [2:0] idx_q, idx_d;
  mode_t      mode_q, mode_d;
  logic       hold_prev_q, hold_prev_d;
  logic [2:0] btn_prev_q, btn_prev_d;
  logic       btn_primed_q, btn_primed_d;
  logic [2:0] chg_q, chg_d;
  logic       moved_q, moved_d;
  status_t    snap_st_q, snap_st_d;
  logic signed [CNT_W-1:0] snap_x_q, snap_x_d, snap_y_q, snap_y_d;
  logic       irq_q, irq_d;
  logic       sig_phase_q, sig_phase_d;

  logic srst, idx_wr, mode_wr, sig_rd;
  logic hold_now, hold_rise, activity, quad_en, tick, snap_en;
  logic [2:0] btn_chg;

  assign qa = {qy_a, qx_a};
  assign qb = {qy_b, qx_b};

  // Strobes
  assign srst     = bus_wr && (bus_addr == PORT_INDEX) && bus_wdata[7];
  assign idx_wr   = bus_wr && (bus_addr == PORT_INDEX);
  assign mode_wr  = bus_wr && (bus_addr == PORT_DATA) && (idx_q == SEL_MODE);
  assign sig_rd   = bus_rd && (bus_addr == PORT_SIG);
  assign hold_now = mode_q.hold;
  assign hold_rise = hold_now & ~hold_prev_q;
  assign quad_en  = (mode_q.kind == 2'b00);
  assign activity = (|chg_q) | moved_q;
  assign snap_en  = hold_rise | srst;

  // Per-axis decoder and live counter
  for (genvar g = 0; g < AXES; g++) begin : g_axis
    qmouse_quad_dec u_dec (
      .clk(clk), .rst_n(rst_n), .clr(srst), .en(quad_en),
      .a(qa[g]), .b(qb[g]), .up(step_up[g]), .dn(step_dn[g])
    );
    qmouse_satcnt #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .clr(srst), .take(hold_rise),
      .up(step_up[g]), .dn(step_dn[g]), .cnt(live_cnt[g])
    );
  end

  qmouse_rate_timer #(.CLK_HZ(CLK_HZ)) u_timer (
    .clk(clk), .rst_n(rst_n), .restart(srst | mode_wr),
    .rate(mode_q.rate), .tick(tick)
  );

  // Next state
  always_comb begin
    btn_chg      = btn_primed_q ? (btn ^ btn_prev_q) : 3'b000;
    btn_prev_d   = btn;
    btn_primed_d = ~srst;

    idx_d = idx_q;
    if (srst)        idx_d = '0;
    else if (idx_wr) idx_d = bus_wdata[2:0];

    mode_d = mode_q;
    if (srst)         mode_d = '0;
    else if (mode_wr) mode_d = mode_t'(bus_wdata);

    hold_prev_d = srst ? 1'b0 : hold_now;

    chg_d   = srst ? 3'b000 : ((hold_rise ? 3'b000 : chg_q) | btn_chg);
    moved_d = srst ? 1'b0 : ((hold_rise ? 1'b0 : moved_q) | (|step_up) | (|step_dn));

    snap_st_d       = snap_st_q;
    snap_st_d.pkt   = srst ? 1'b0 : activity;
    snap_st_d.moved = srst ? 1'b0 : moved_q;
    snap_st_d.chg   = srst ? 3'b000 : chg_q;
    snap_st_d.down  = srst ? 3'b000 : btn;
    snap_x_d        = srst ? '0 : live_cnt[0];
    snap_y_d        = srst ? '0 : live_cnt[1];

    if (srst || hold_rise) irq_d = 1'b0;
    else irq_d = irq_q | (activity & (mode_q.dat_en | (mode_q.tmr_en & tick)));

    if (srst)        sig_phase_d = 1'b0;
    else if (sig_rd) sig_phase_d = ~sig_phase_q;
    else             sig_phase_d = sig_phase_q;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q        <= '0;
      mode_q       <= '0;
      hold_prev_q  <= 1'b0;
      btn_prev_q   <= '0;
      btn_primed_q <= 1'b0;
      chg_q        <= '0;
      moved_q      <= 1'b0;
      irq_q        <= 1'b0;
      sig_phase_q  <= 1'b0;
    end else begin
      idx_q        <= idx_d;
      mode_q       <= mode_d;
      hold_prev_q  <= hold_prev_d;
      btn_prev_q   <= btn_prev_d;
      btn_primed_q <= btn_primed_d;
      chg_q        <= chg_d;
      moved_q      <= moved_d;
      irq_q        <= irq_d;
      sig_phase_q  <= sig_phase_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_st_q <= '0;
      snap_x_q  <= '0;
      snap_y_q  <= '0;
    end else if (snap_en) begin
      snap_st_q <= snap_st_d;
      snap_x_q  <= snap_x_d;
      snap_y_q  <= snap_y_d;
    end
  end

  // Read mux
  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      PORT_INDEX: bus_rdata = {5'b00000, idx_q};
      PORT_DATA: begin
        if (idx_q == SEL_MODE) bus_rdata = mode_q;
        else if (hold_now) begin
          case (idx_q)
            SEL_STATUS: bus_rdata = snap_st_q;
            SEL_XCNT:   bus_rdata = DATA_W'(snap_x_q);
            SEL_YCNT:   bus_rdata = DATA_W'(snap_y_q);
            default:    bus_rdata = '0;
          endcase
        end
      end
      PORT_SIG: bus_rdata = sig_phase_q ? SIG_ODD : SIG_EVEN;
      default:  bus_rdata = '0;
    endcase
  end

  assign irq = irq_q;
endmodule

// File: rtl/qmouse_ctrl_chk.sv
module qmouse_ctrl_chk #(
  parameter int CNT_W = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    srst,
  input logic                    hold_now,
  input logic                    hold_prev,
  input logic                    hold_rise,
  input logic                    x_up,
  input logic                    x_dn,
  input logic signed [CNT_W-1:0] live_x,
  input logic signed [CNT_W-1:0] snap_x,
  input logic                    irq,
  input logic                    activity,
  input logic                    dat_en,
  input logic                    tmr_en,
  input logic [2:0]              rate,
  input logic [1:0]              kind,
  input logic                    sig_phase,
  input logic                    bus_rd,
  input logic [1:0]              bus_addr,
  input logic [7:0]              bus_rdata
);
  localparam logic signed [CNT_W-1:0] MAXV = {1'b0, {(CNT_W-1){1'b1}}};
  localparam logic signed [CNT_W-1:0] MINV = {1'b1, {(CNT_W-1){1'b0}}};

  AST_SAT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (live_x == MAXV && x_up && !x_dn && !hold_rise && !srst) |=> (live_x == MAXV)); // R3
  AST_SAT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (live_x == MINV && x_dn && !x_up && !hold_rise && !srst) |=> (live_x == MINV)); // R3
  AST_HOLD_CLEARS_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_rise && !srst && !x_up && !x_dn) |=> (live_x == '0)); // R5
  AST_SNAP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_now && hold_prev && !srst) |=> $stable(snap_x)); // R6
  AST_IRQ_NEEDS_ACTIVITY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(activity)); // R8
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!dat_en && !(tmr_en && rate != 3'd0) && !irq) |=> !irq); // R10
  AST_SIG_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 2'd2 && !srst) |=> (sig_phase != $past(sig_phase))); // R11
  AST_SIG_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 2'd2) |-> (bus_rdata == 8'hDE || bus_rdata == 8'h11)); // R11
  AST_KIND_GATES_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (kind != 2'b00) |-> (!x_up && !x_dn)); // R12
endmodule

bind qmouse_ctrl qmouse_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .srst(srst), .hold_now(hold_now),
  .hold_prev(hold_prev_q), .hold_rise(hold_rise),
  .x_up(step_up[0]), .x_dn(step_dn[0]), .live_x(live_cnt[0]),
  .snap_x(snap_x_q), .irq(irq_q), .activity(activity),
  .dat_en(mode_q.dat_en), .tmr_en(mode_q.tmr_en), .rate(mode_q.rate),
  .kind(mode_q.kind), .sig_phase(sig_phase_q), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata)
);

// File: tb/qmouse_ctrl_tb.sv
`timescale 1ns/1ps
module qmouse_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       qx_a = 1'b0, qx_b = 1'b0, qy_a = 1'b0, qy_b = 1'b0;
  logic [2:0] btn = 3'b000;
  logic [1:0] bus_addr = 2'd0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       irq;

  int checks = 0;
  int errors = 0;
  int xi = 0, yi = 0;
  logic [1:0] seq [4] = '{2'b00, 2'b10, 2'b11, 2'b01};

  always #2 clk = ~clk;

  qmouse_ctrl #(.CLK_HZ(60000), .CNT_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .qx_a(qx_a), .qx_b(qx_b), .qy_a(qy_a), .qy_b(qy_b),
    .btn(btn), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 v = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic reg_write(input logic [2:0] sel, input logic [7:0] d);
    bus_write(2'd0, {5'b0, sel});
    bus_write(2'd1, d);
  endtask

  task automatic reg_read(input logic [2:0] sel, output logic [7:0] v);
    bus_write(2'd0, {5'b0, sel});
    bus_read(2'd1, v);
  endtask

  task automatic step_x(input bit fwd);
    @(negedge clk);
    xi = fwd ? (xi + 1) % 4 : (xi + 3) % 4;
    {qx_a, qx_b} = seq[xi];
    @(negedge clk);
  endtask

  task automatic step_y(input bit fwd);
    @(negedge clk);
    yi = fwd ? (yi + 1) % 4 : (yi + 3) % 4;
    {qy_a, qy_b} = seq[yi];
    @(negedge clk);
  endtask

  task automatic hold_set();   reg_write(3'd7, 8'h20); endtask
  task automatic hold_clear(); reg_write(3'd7, 8'h00); endtask
  task automatic flush();      hold_set(); hold_clear(); endtask

  task automatic t_reset();
    logic [7:0] v;
    check(irq == 1'b0, "R13 irq after reset", int'(irq), 0);
    bus_read(2'd0, v); check(v == 8'h00, "R1 index after reset", v, 8'h00);
    bus_read(2'd1, v); check(v == 8'h00, "R6 status with hold clear", v, 8'h00);
  endtask

  task automatic t_index();
    logic [7:0] v;
    bus_write(2'd0, 8'h07); bus_read(2'd0, v);
    check(v == 8'h07, "R1 index readback", v, 8'h07);
    bus_write(2'd0, 8'h7B); bus_read(2'd0, v);
    check(v == 8'h03, "R1 index uses bits 2:0", v, 8'h03);
    reg_read(3'd7, v); check(v == 8'h00, "R7 mode after reset", v, 8'h00);
  endtask

  task automatic t_motion();
    logic [7:0] v;
    flush();
    for (int i = 0; i < 5; i++) step_x(1'b1);
    @(negedge clk); xi = (xi + 2) % 4; {qx_a, qx_b} = seq[xi]; @(negedge clk);
    step_x(1'b1);
    for (int i = 0; i < 3; i++) step_y(1'b0);
    hold_set();
    reg_read(3'd1, v); check(v == 8'h06, "R2 X forward with jump ignored", v, 8'h06);
    reg_read(3'd2, v); check(v == 8'hFD, "R2 Y reverse", v, 8'hFD);
    reg_read(3'd0, v); check(v == 8'hC0, "R5 status moved+packet", v, 8'hC0);
    hold_clear();
  endtask

  task automatic t_hold_no_loss();
    logic [7:0] v;
    flush();
    hold_set();
    step_x(1'b1); step_x(1'b1);
    reg_read(3'd1, v); check(v == 8'h00, "R6 snapshot frozen under hold", v, 8'h00);
    hold_clear(); hold_set();
    reg_read(3'd1, v); check(v == 8'h02, "R5 motion during hold kept", v, 8'h02);
    reg_read(3'd0, v); check(v == 8'hC0, "R5 moved in next snapshot", v, 8'hC0);
    hold_clear();
  endtask

  task automatic t_buttons();
    logic [7:0] v;
    flush();
    @(negedge clk); btn = 3'b100; @(negedge clk);
    hold_set(); reg_read(3'd0, v);
    check(v == 8'hA4, "R4 left press status", v, 8'hA4);
    hold_clear();
    @(negedge clk); btn = 3'b001; @(negedge clk); @(negedge clk);
    hold_set(); reg_read(3'd0, v);
    check(v == 8'hA9, "R4 left release right press", v, 8'hA9);
    hold_clear();
    @(negedge clk); btn = 3'b000;
    flush();
  endtask

  task automatic t_saturate();
    logic [7:0] v;
    flush();
    for (int i = 0; i < 130; i++) step_x(1'b1);
    hold_set(); reg_read(3'd1, v);
    check(v == 8'h7F, "R3 saturate high", v, 8'h7F);
    hold_clear();
    for (int i = 0; i < 135; i++) step_x(1'b0);
    hold_set(); reg_read(3'd1, v);
    check(v == 8'h80, "R3 saturate low", v, 8'h80);
    hold_clear();
  endtask

  task automatic t_ignored_writes();
    logic [7:0] v;
    flush();
    for (int i = 0; i < 4; i++) step_x(1'b1);
    hold_set();
    reg_write(3'd1, 8'h55); reg_write(3'd0, 8'h55);
    reg_read(3'd1, v); check(v == 8'h04, "R7 write to X ignored", v, 8'h04);
    reg_read(3'd0, v); check(v == 8'hC0, "R7 write to status ignored", v, 8'hC0);
    hold_clear();
    reg_read(3'd1, v); check(v == 8'h00, "R6 X reads 0 with hold clear", v, 8'h00);
    reg_write(3'd7, 8'h07); reg_read(3'd7, v);
    check(v == 8'h07, "R7 mode readback", v, 8'h07);
    reg_write(3'd7, 8'h00);
  endtask

  task automatic t_kind();
    logic [7:0] v;
    flush();
    reg_write(3'd7, 8'h40);
    for (int i = 0; i < 3; i++) step_x(1'b1);
    hold_set();
    reg_read(3'd1, v); check(v == 8'h00, "R12 steps ignored in other kind", v, 8'h00);
    reg_read(3'd0, v); check(v == 8'h00, "R12 no moved flag", v, 8'h00);
    hold_clear();
  endtask

  task automatic t_data_irq();
    flush();
    reg_write(3'd7, 8'h08);
    repeat (5) @(negedge clk);
    check(irq == 1'b0, "R10 no irq without activity", int'(irq), 0);
    step_x(1'b1);
    @(negedge clk);
    check(irq == 1'b1, "R8 data irq on motion", int'(irq), 1);
    reg_write(3'd7, 8'h28);
    @(negedge clk);
    check(irq == 1'b0, "R10 hold rise clears irq", int'(irq), 0);
    hold_clear();
  endtask

  task automatic measure(input logic [7:0] mode, input int exp, input string req);
    int n;
    flush();
    step_x(1'b1);
    bus_write(2'd0, 8'h07);
    bus_write(2'd1, mode);
    n = 0;
    while (!irq && n < 5000) begin @(negedge clk); n++; end
    check(n == exp, req, n, exp);
    flush();
  endtask

  task automatic t_timer_irq();
    measure(8'h14, 300, "R9 timer 200 Hz period");
    measure(8'h11, 2000, "R9 timer 30 Hz period");
    measure(8'h16, 1, "R9 timer always");
    flush();
    step_x(1'b1);
    reg_write(3'd7, 8'h10);
    repeat (2500) @(negedge clk);
    check(irq == 1'b0, "R10 rate 0 never", int'(irq), 0);
    flush();
  endtask

  task automatic t_signature();
    logic [7:0] v;
    bus_read(2'd2, v); check(v == 8'hDE, "R11 first signature", v, 8'hDE);
    bus_read(2'd2, v); check(v == 8'h11, "R11 second signature", v, 8'h11);
    bus_read(2'd0, v); bus_read(2'd1, v);
    bus_read(2'd2, v); check(v == 8'hDE, "R11 other reads do not advance", v, 8'hDE);
  endtask

  task automatic t_soft_reset();
    logic [7:0] v;
    reg_write(3'd7, 8'h07);
    bus_write(2'd0, 8'h02);
    bus_read(2'd2, v);
    step_x(1'b1);
    bus_write(2'd0, 8'h80);
    bus_read(2'd0, v); check(v == 8'h00, "R13 index cleared", v, 8'h00);
    reg_read(3'd7, v); check(v == 8'h00, "R13 mode cleared", v, 8'h00);
    bus_read(2'd2, v); check(v == 8'hDE, "R13 signature phase cleared", v, 8'hDE);
    hold_set();
    reg_read(3'd1, v); check(v == 8'h00, "R13 live count cleared", v, 8'h00);
    reg_read(3'd0, v); check(v == 8'h00, "R13 flags cleared", v, 8'h00);
    hold_clear();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_index();
    t_motion();
    t_hold_no_loss();
    t_buttons();
    t_saturate();
    t_ignored_writes();
    t_kind();
    t_data_irq();
    t_timer_irq();
    t_signature();
    t_soft_reset();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule